// File: doc/BRIEF.md
# Asymmetric Dual-Port RAM with Write-Collision Flagging

This block is a synchronous two-port memory in which both ports address one shared store at different word widths. Port A sees narrow words of `A_WIDTH` bits over `A_DEPTH` locations. Port B sees words `RATIO` times wider over `A_DEPTH / RATIO` locations. Each port can read or write in every cycle, and both ports run from one clock. A wide word on port B is made of `RATIO` narrow words. The narrow word with the lowest port A address sits in the least significant slice.

Each port returns its data one cycle after the access, through a registered output and a valid flag. A single parameter selects what a writing port shows on its output: the old contents, the new data, or its unchanged previous value. The two ports collide when they write overlapping storage in the same cycle. In that case both writes are dropped, both valid flags go low for one cycle, and both outputs keep their previous values. The store starts from an image given as a parameter.

Top module: `asym_dpram`

## Requirements
- R1: `RATIO` must be one of 1, 2, 4, 8, 16 or 32, and `A_DEPTH` must be a multiple of it; port B depth is `A_DEPTH / RATIO` and its width is `RATIO * A_WIDTH`.
- R2: Port A address `a` maps to bits `[(a % RATIO)*A_WIDTH +: A_WIDTH]` of port B row `a / RATIO`.
- R3: With its write enable low, a port presents the stored word at its address on its output one clock edge later.
- R4: In read-first mode (`WMODE = WM_READ_FIRST`), a writing port outputs the contents the location held before the write.
- R5: In write-first mode (`WMODE = WM_WRITE_FIRST`), a writing port outputs the data it is writing.
- R6: In no-change mode (`WMODE = WM_NO_CHANGE`), a writing port keeps its previous output value.
- R7: When both ports write in one cycle and `a_addr / RATIO == b_addr`, neither write alters memory.
- R8: After a collision cycle both valid flags are 0 and both outputs hold their previous values. After any other cycle out of reset both valid flags are 1.
- R9: Before any write, memory holds `INIT_IMAGE`, with port A word `i` at bits `[i*A_WIDTH +: A_WIDTH]`.
- R10: While synchronous reset `rst` is high, outputs clear to zero and valid flags to 0 at each clock edge. Memory contents are kept.
- R11: Legal addresses are 0 to `A_DEPTH-1` on port A and 0 to `A_DEPTH/RATIO-1` on port B, and the top legal address is usable. An address beyond these ranges raises an error in simulation.
- R12: When one port writes a location that the other port reads in the same cycle (no collision), the reading port returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset of output registers |
| a_addr | input | clog2(A_DEPTH) | Port A word address |
| a_din | input | A_WIDTH | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_dout | output | A_WIDTH | Port A registered read data |
| a_valid | output | 1 | Port A output valid |
| b_addr | input | clog2(A_DEPTH/RATIO) | Port B row address |
| b_din | input | RATIO*A_WIDTH | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_dout | output | RATIO*A_WIDTH | Port B registered read data |
| b_valid | output | 1 | Port B output valid |

## Verification
The checks assume that both addresses stay inside their legal ranges in every cycle out of reset. They also assume that both ports are driven from the single shared clock, so one edge decides collisions and cross-port reads. The stimulus draws port A addresses from 0 to `A_DEPTH-1` and port B rows from 0 to `A_DEPTH/RATIO-1`, and deliberately includes the top address of each range. It makes port B target the row that port A is addressing in about a third of random cycles, so collisions and cross-port read-during-write occur often, while never leaving the legal ranges.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;

    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_MEM   = 2'd1,
        SRC_WDATA = 2'd2
    } out_src_e;

    typedef struct packed {
        out_src_e src;
        logic     valid;
    } port_ctl_t;

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic bit ratio_legal(int r);
        return (r == 1) || (r == 2) || (r == 4) || (r == 8) || (r == 16) || (r == 32);
    endfunction

    function automatic port_ctl_t out_select(logic we, logic clash, wmode_e mode);
        port_ctl_t c;
        c.valid = !clash;
        if (clash) begin
            c.src = SRC_HOLD;
        end else if (!we) begin
            c.src = SRC_MEM;
        end else begin
            case (mode)
                WM_READ_FIRST:  c.src = SRC_MEM;
                WM_WRITE_FIRST: c.src = SRC_WDATA;
                default:        c.src = SRC_HOLD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/asym_dpram_lane.sv
module asym_dpram_lane #(
    parameter int A_WIDTH = 8,
    parameter int RATIO   = 4,
    parameter int LANE    = 0,
    parameter int B_DEPTH = 12,
    parameter int BW      = 4,
    parameter logic [A_WIDTH*B_DEPTH*RATIO-1:0] INIT_IMAGE = '0
) (
    input  logic               clk,
    input  logic               a_we,
    input  logic [BW-1:0]      a_row,
    input  logic [A_WIDTH-1:0] a_wdata,
    input  logic               b_we,
    input  logic [BW-1:0]      b_row,
    input  logic [A_WIDTH-1:0] b_wdata,
    output logic [A_WIDTH-1:0] a_q,
    output logic [A_WIDTH-1:0] b_q
);

    logic [A_WIDTH-1:0] cells [B_DEPTH];

    // Preload this lane's slice of the image: row r holds narrow word r*RATIO+LANE.
    initial begin
        for (int r = 0; r < B_DEPTH; r++) begin
            cells[r] = INIT_IMAGE[(r*RATIO + LANE)*A_WIDTH +: A_WIDTH];
        end
    end

    // Write enables arrive already qualified for range and collision.
    always_ff @(posedge clk) begin
        if (a_we) cells[a_row] <= a_wdata;
        if (b_we) cells[b_row] <= b_wdata;
    end

    // Read side is combinational; the port output register adds the latency.
    always_comb begin
        a_q = (int'(a_row) < B_DEPTH) ? cells[a_row] : '0;
        b_q = (int'(b_row) < B_DEPTH) ? cells[b_row] : '0;
    end

endmodule

// File: rtl/asym_dpram_arb.sv
module asym_dpram_arb
    import asym_dpram_pkg::*;
#(
    parameter int     A_DEPTH = 48,
    parameter int     RATIO   = 4,
    parameter int     AW      = 6,
    parameter int     BW      = 4,
    parameter int     LW      = 2,
    parameter wmode_e WMODE   = WM_READ_FIRST
) (
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [BW-1:0] b_addr,
    input  logic          b_we,
    output logic [BW-1:0] a_row,
    output logic [LW-1:0] a_lane,
    output logic          a_wr,
    output logic          b_wr,
    output port_ctl_t     a_ctl,
    output port_ctl_t     b_ctl
);

    localparam int B_DEPTH = A_DEPTH / RATIO;

    logic a_in_range;
    logic b_in_range;
    logic clash;

    always_comb begin
        a_row      = BW'(int'(a_addr) / RATIO);
        a_lane     = LW'(int'(a_addr) % RATIO);
        a_in_range = int'(a_addr) < A_DEPTH;
        b_in_range = int'(b_addr) < B_DEPTH;
        // Full-width compare so a wide A address cannot alias onto a B row.
        clash      = a_we && b_we && ((int'(a_addr) / RATIO) == int'(b_addr));
        a_wr       = a_we && a_in_range && !clash;
        b_wr       = b_we && b_in_range && !clash;
        a_ctl      = out_select(a_we, clash, WMODE);
        b_ctl      = out_select(b_we, clash, WMODE);
    end

endmodule

// File: rtl/asym_dpram_oreg.sv
module asym_dpram_oreg
    import asym_dpram_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  port_ctl_t    ctl,
    input  logic [W-1:0] mem_q,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dout,
    output logic         valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= ctl.valid;
            case (ctl.src)
                SRC_MEM:   dout <= mem_q;
                SRC_WDATA: dout <= wdata;
                default:   dout <= dout;
            endcase
        end
    end

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
    import asym_dpram_pkg::*;
#(
    parameter int     A_WIDTH = 8,
    parameter int     A_DEPTH = 48,
    parameter int     RATIO   = 4,
    parameter wmode_e WMODE   = WM_READ_FIRST,
    parameter logic [A_DEPTH*A_WIDTH-1:0] INIT_IMAGE = '0,
    localparam int    B_DEPTH = A_DEPTH / RATIO,
    localparam int    B_WIDTH = A_WIDTH * RATIO,
    localparam int    AW      = idx_width(A_DEPTH),
    localparam int    BW      = idx_width(B_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      a_addr,
    input  logic [A_WIDTH-1:0] a_din,
    input  logic               a_we,
    output logic [A_WIDTH-1:0] a_dout,
    output logic               a_valid,
    input  logic [BW-1:0]      b_addr,
    input  logic [B_WIDTH-1:0] b_din,
    input  logic               b_we,
    output logic [B_WIDTH-1:0] b_dout,
    output logic               b_valid
);

    localparam int LW = idx_width(RATIO);

    if (!ratio_legal(RATIO)) begin : g_bad_ratio
        $error("asym_dpram: RATIO must be 1, 2, 4, 8, 16 or 32");
    end
    if ((A_DEPTH % RATIO) != 0) begin : g_bad_depth
        $error("asym_dpram: A_DEPTH must be a multiple of RATIO");
    end

    logic [BW-1:0]      a_row;
    logic [LW-1:0]      a_lane;
    logic               a_wr;
    logic               b_wr;
    port_ctl_t          a_ctl;
    port_ctl_t          b_ctl;
    logic [A_WIDTH-1:0] lane_a_q [RATIO];
    logic [A_WIDTH-1:0] lane_b_q [RATIO];
    logic [A_WIDTH-1:0] a_mem_q;
    logic [B_WIDTH-1:0] b_mem_q;

    asym_dpram_arb #(
        .A_DEPTH (A_DEPTH),
        .RATIO   (RATIO),
        .AW      (AW),
        .BW      (BW),
        .LW      (LW),
        .WMODE   (WMODE)
    ) u_arb (
        .a_addr (a_addr),
        .a_we   (a_we),
        .b_addr (b_addr),
        .b_we   (b_we),
        .a_row  (a_row),
        .a_lane (a_lane),
        .a_wr   (a_wr),
        .b_wr   (b_wr),
        .a_ctl  (a_ctl),
        .b_ctl  (b_ctl)
    );

    // One storage lane per narrow slice of a wide word; lane 0 is least significant.
    for (genvar l = 0; l < RATIO; l++) begin : g_lane
        logic lane_a_we;
        assign lane_a_we = a_wr && (a_lane == LW'(l));

        asym_dpram_lane #(
            .A_WIDTH    (A_WIDTH),
            .RATIO      (RATIO),
            .LANE       (l),
            .B_DEPTH    (B_DEPTH),
            .BW         (BW),
            .INIT_IMAGE (INIT_IMAGE)
        ) u_lane (
            .clk     (clk),
            .a_we    (lane_a_we),
            .a_row   (a_row),
            .a_wdata (a_din),
            .b_we    (b_wr),
            .b_row   (b_addr),
            .b_wdata (b_din[l*A_WIDTH +: A_WIDTH]),
            .a_q     (lane_a_q[l]),
            .b_q     (lane_b_q[l])
        );

        assign b_mem_q[l*A_WIDTH +: A_WIDTH] = lane_b_q[l];
    end

    always_comb begin
        a_mem_q = '0;
        for (int l = 0; l < RATIO; l++) begin
            if (a_lane == LW'(l)) a_mem_q = lane_a_q[l];
        end
    end

    asym_dpram_oreg #(.W(A_WIDTH)) u_oreg_a (
        .clk   (clk),
        .rst   (rst),
        .ctl   (a_ctl),
        .mem_q (a_mem_q),
        .wdata (a_din),
        .dout  (a_dout),
        .valid (a_valid)
    );

    asym_dpram_oreg #(.W(B_WIDTH)) u_oreg_b (
        .clk   (clk),
        .rst   (rst),
        .ctl   (b_ctl),
        .mem_q (b_mem_q),
        .wdata (b_din),
        .dout  (b_dout),
        .valid (b_valid)
    );

endmodule

// File: rtl/asym_dpram_chk.sv
module asym_dpram_chk
    import asym_dpram_pkg::*;
#(
    parameter int     A_WIDTH = 8,
    parameter int     A_DEPTH = 48,
    parameter int     RATIO   = 4,
    parameter wmode_e WMODE   = WM_READ_FIRST,
    parameter int     AW      = 6,
    parameter int     BW      = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [AW-1:0]              a_addr,
    input logic [A_WIDTH-1:0]         a_din,
    input logic                       a_we,
    input logic [A_WIDTH-1:0]         a_dout,
    input logic                       a_valid,
    input logic [BW-1:0]              b_addr,
    input logic [A_WIDTH*RATIO-1:0]   b_din,
    input logic                       b_we,
    input logic [A_WIDTH*RATIO-1:0]   b_dout,
    input logic                       b_valid
);

    localparam int B_DEPTH = A_DEPTH / RATIO;

    logic overlap_wr;
    assign overlap_wr = a_we && b_we && ((int'(a_addr) / RATIO) == int'(b_addr));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!a_valid && !b_valid && a_dout == '0 && b_dout == '0));

    // R8
    collide_flag_chk: assert property (@(posedge clk) disable iff (rst)
        overlap_wr |=> (!a_valid && !b_valid && $stable(a_dout) && $stable(b_dout)));

    // R8
    valid_high_chk: assert property (@(posedge clk) disable iff (rst)
        !overlap_wr |=> (a_valid && b_valid));

    // R5
    write_first_a_chk: assert property (@(posedge clk) disable iff (rst)
        (WMODE == WM_WRITE_FIRST) && a_we && !overlap_wr |=> a_dout == $past(a_din));

    // R5
    write_first_b_chk: assert property (@(posedge clk) disable iff (rst)
        (WMODE == WM_WRITE_FIRST) && b_we && !overlap_wr |=> b_dout == $past(b_din));

    // R6
    no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (WMODE == WM_NO_CHANGE) && a_we && !overlap_wr |=> $stable(a_dout));

    // R11
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(a_addr) < A_DEPTH) && (int'(b_addr) < B_DEPTH))
        else $error("asym_dpram: address out of range (a=%0d b=%0d)", a_addr, b_addr);

endmodule

bind asym_dpram asym_dpram_chk #(
    .A_WIDTH (A_WIDTH),
    .A_DEPTH (A_DEPTH),
    .RATIO   (RATIO),
    .WMODE   (WMODE),
    .AW      (AW),
    .BW      (BW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_addr  (a_addr),
    .a_din   (a_din),
    .a_we    (a_we),
    .a_dout  (a_dout),
    .a_valid (a_valid),
    .b_addr  (b_addr),
    .b_din   (b_din),
    .b_we    (b_we),
    .b_dout  (b_dout),
    .b_valid (b_valid)
);

// File: tb/asym_dpram_test.sv
module asym_dpram_test;
    import asym_dpram_pkg::*;

    localparam int AWD  = 8;
    localparam int ADEP = 48;
    localparam int RAT  = 4;
    localparam int BDEP = ADEP / RAT;
    localparam int BWD  = AWD * RAT;

    function automatic logic [AWD-1:0] seed_word(int i);
        return AWD'(i * 29 + 7);
    endfunction

    function automatic logic [ADEP*AWD-1:0] make_image();
        logic [ADEP*AWD-1:0] v;
        v = '0;
        for (int i = 0; i < ADEP; i++) v[i*AWD +: AWD] = seed_word(i);
        return v;
    endfunction

    localparam logic [ADEP*AWD-1:0] IMAGE = make_image();

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [5:0]     a_addr = '0;
    logic [AWD-1:0] a_din = '0;
    logic           a_we = 1'b0;
    logic [3:0]     b_addr = '0;
    logic [BWD-1:0] b_din = '0;
    logic           b_we = 1'b0;

    logic [AWD-1:0] a_dout [3];
    logic           a_valid [3];
    logic [BWD-1:0] b_dout [3];
    logic           b_valid [3];

    always #10 clk = ~clk;

    asym_dpram #(.A_WIDTH(AWD), .A_DEPTH(ADEP), .RATIO(RAT), .WMODE(WM_READ_FIRST), .INIT_IMAGE(IMAGE)) uut (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_din(a_din), .a_we(a_we), .a_dout(a_dout[0]), .a_valid(a_valid[0]),
        .b_addr(b_addr), .b_din(b_din), .b_we(b_we), .b_dout(b_dout[0]), .b_valid(b_valid[0]));

    asym_dpram #(.A_WIDTH(AWD), .A_DEPTH(ADEP), .RATIO(RAT), .WMODE(WM_WRITE_FIRST), .INIT_IMAGE(IMAGE)) uut_wf (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_din(a_din), .a_we(a_we), .a_dout(a_dout[1]), .a_valid(a_valid[1]),
        .b_addr(b_addr), .b_din(b_din), .b_we(b_we), .b_dout(b_dout[1]), .b_valid(b_valid[1]));

    asym_dpram #(.A_WIDTH(AWD), .A_DEPTH(ADEP), .RATIO(RAT), .WMODE(WM_NO_CHANGE), .INIT_IMAGE(IMAGE)) uut_nc (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_din(a_din), .a_we(a_we), .a_dout(a_dout[2]), .a_valid(a_valid[2]),
        .b_addr(b_addr), .b_din(b_din), .b_we(b_we), .b_dout(b_dout[2]), .b_valid(b_valid[2]));

    // Behavioural reference: a flat array of narrow words plus expected outputs per mode.
    logic [AWD-1:0] model [ADEP];
    logic [AWD-1:0] exp_a [3];
    logic [BWD-1:0] exp_b [3];
    logic           exp_va;
    logic           exp_vb;
    int             vectors = 0;
    int             errors  = 0;
    bit             done    = 0;

    task automatic cmp(string tag, string what, logic [BWD-1:0] act, logic [BWD-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [BWD-1:0] model_row(int r);
        logic [BWD-1:0] v;
        for (int l = 0; l < RAT; l++) v[l*AWD +: AWD] = model[r*RAT + l];
        return v;
    endfunction

    task automatic compare_all(string tag);
        for (int m = 0; m < 3; m++) begin
            cmp(tag, $sformatf("mode%0d a_dout", m), BWD'(a_dout[m]), BWD'(exp_a[m]));
            cmp(tag, $sformatf("mode%0d a_valid", m), BWD'(a_valid[m]), BWD'(exp_va));
            cmp(tag, $sformatf("mode%0d b_dout", m), b_dout[m], exp_b[m]);
            cmp(tag, $sformatf("mode%0d b_valid", m), BWD'(b_valid[m]), BWD'(exp_vb));
        end
    endtask

    // Drive one cycle at a falling edge, predict, and compare at the next falling edge.
    task automatic step(int aa, logic [AWD-1:0] da, logic wa, int ab, logic [BWD-1:0] db, logic wb, string tag);
        logic           clash;
        logic [AWD-1:0] old_a;
        logic [BWD-1:0] old_b;
        a_addr = 6'(aa); a_din = da; a_we = wa;
        b_addr = 4'(ab); b_din = db; b_we = wb;
        clash = wa && wb && ((aa / RAT) == ab);
        old_a = model[aa];
        old_b = model_row(ab);
        exp_va = !clash;
        exp_vb = !clash;
        for (int m = 0; m < 3; m++) begin
            if (!clash) begin
                if (!wa)         exp_a[m] = old_a;
                else if (m == 0) exp_a[m] = old_a;
                else if (m == 1) exp_a[m] = da;
                if (!wb)         exp_b[m] = old_b;
                else if (m == 0) exp_b[m] = old_b;
                else if (m == 1) exp_b[m] = db;
            end
        end
        if (!clash) begin
            if (wa) model[aa] = da;
            if (wb) for (int l = 0; l < RAT; l++) model[ab*RAT + l] = db[l*AWD +: AWD];
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        a_we = 1'b0; b_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            exp_a[m] = '0;
            exp_b[m] = '0;
        end
        exp_va = 1'b0;
        exp_vb = 1'b0;
        compare_all("R10");
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual still running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < ADEP; i++) model[i] = seed_word(i);
        @(negedge clk);
        do_reset();

        // R9 / R3: initial image read through both ports
        for (int i = 0; i < ADEP; i++) step(i, '0, 1'b0, i % BDEP, '0, 1'b0, "R9");

        // R2: narrow writes assemble a wide row; top row and top address (R11, R1)
        step(44, 8'hA1, 1'b1, 0, '0, 1'b0, "R2");
        step(45, 8'hB2, 1'b1, 0, '0, 1'b0, "R2");
        step(46, 8'hC3, 1'b1, 0, '0, 1'b0, "R2");
        step(47, 8'hD4, 1'b1, 0, '0, 1'b0, "R11");
        step(0, '0, 1'b0, 11, '0, 1'b0, "R1");

        // R2: a wide write read back lane by lane through port A
        step(0, '0, 1'b0, 3, 32'h4433_2211, 1'b1, "R2");
        for (int l = 0; l < RAT; l++) step(12 + l, '0, 1'b0, 3, '0, 1'b0, "R2");

        // R4 R5 R6: writes on each port under every output mode
        step(5, 8'h5A, 1'b1, 7, '0, 1'b0, "R4 R5 R6");
        step(5, 8'h6B, 1'b1, 7, '0, 1'b0, "R4 R5 R6");
        step(9, '0, 1'b0, 7, 32'hDEAD_BEEF, 1'b1, "R4 R5 R6");
        step(9, '0, 1'b0, 7, 32'h0BAD_F00D, 1'b1, "R4 R5 R6");
        step(9, '0, 1'b0, 7, '0, 1'b0, "R3");

        // R12: one port writes what the other reads in the same cycle
        step(21, 8'h77, 1'b1, 5, '0, 1'b0, "R12");
        step(20, '0, 1'b0, 5, 32'h1234_5678, 1'b1, "R12");
        step(21, '0, 1'b0, 5, '0, 1'b0, "R12");

        // R7 R8: overlapping writes are dropped and flagged, then read back
        step(33, 8'hEE, 1'b1, 8, 32'hCAFE_CAFE, 1'b1, "R8");
        step(33, 8'h11, 1'b1, 8, 32'h2222_3333, 1'b1, "R8");
        step(33, '0, 1'b0, 8, '0, 1'b0, "R7");
        step(32, 8'h99, 1'b1, 9, 32'h5555_6666, 1'b1, "R8");
        step(32, '0, 1'b0, 9, '0, 1'b0, "R3");

        // R10: reset mid-run clears outputs but keeps the stored data
        step(2, 8'h3C, 1'b1, 1, '0, 1'b0, "R4 R5 R6");
        do_reset();
        step(2, '0, 1'b0, 0, '0, 1'b0, "R10");

        // Mixed traffic inside the legal ranges (R11), biased toward shared rows
        for (int i = 0; i < 1500; i++) begin
            int aa;
            int ab;
            aa = $urandom_range(ADEP - 1);
            ab = ($urandom_range(2) == 0) ? aa / RAT : $urandom_range(BDEP - 1);
            step(aa, AWD'($urandom), 1'($urandom), ab, BWD'($urandom), 1'($urandom), "R3 R7 R8 R12");
        end

        finish_run();
    end

endmodule